// File: doc/BRIEF.md
# Gated Prescaled Period Timer

A 16-bit up-counting timer with a write port for three registers: the count, the period and a control word. Each qualified source tick passes through a selectable prescaler. When the prescaler's output tick arrives while the count equals the period, the count returns to zero. In that cycle a one-cycle match pulse is produced and a sticky event flag is set.

The tick source is either the internal core cycle or rising edges of an external input. The external input is already synchronized into the core clock domain. In gate mode the same input instead enables counting of internal cycles while it is high. A pulse marks the end of each gate window. Idle and sleep status lines qualify counting. Idle can freeze the timer if the control word requests it. Sleep allows counting only from an unsynchronized external source.

Top module: `gp_timer`

## Requirements
- R1: After reset the count is 0x0000, the period is 0xFFFF, the control word is 0 (timer disabled), and `count_o`, `match_o`, `flag_o` and `gate_end_o` are all 0.
- R2: `wr_sel_i` selects the written register when `wr_en_i` is high: 0 selects the count, 1 the period, 2 the control word, and 3 is ignored. The control word layout is: bit0 enable, bit1 external source, bit2 external sync, bit3 gate enable, bits5:4 prescale, bit6 idle stop. Writing the control word leaves the count unchanged.
- R3: The prescale field selects the number of source ticks per count step: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 256.
- R4: While the timer is enabled, a count write or a control write clears the prescaler. A count write takes priority over an increment in the same cycle.
- R5: With the internal source selected, the timer sees one source tick per enabled cycle. With the external source selected, it sees one source tick per rising edge of `ext_i` (high now, low in the previous cycle).
- R6: Gate mode requires enable = 1, gate enable = 1 and the internal source. In this mode a source tick occurs only in cycles where `ext_i` is high. `gate_end_o` is high in the cycle where `ext_i` is low after having been high in the previous cycle.
- R7: On a prescaled tick with count equal to the period and no count write, the count becomes 0 and `match_o` is high for that one following cycle.
- R8: `flag_o` is set by every match event and stays set until `flag_clr_i` is high without a simultaneous match. A set takes priority over a clear.
- R9: While `idle_i` is high and idle stop = 1, the count and the prescaler are frozen. With idle stop = 0, the timer keeps counting during idle.
- R10: While `sleep_i` is high, the timer counts only if the external source is selected and external sync = 0. Otherwise it holds its state.
- R11: While enable = 0, the count changes only through a count write, and the prescaler holds its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 count, 1 period, 2 control) |
| wr_data_i | input | 16 | Write data |
| flag_clr_i | input | 1 | Clears the event flag |
| ext_i | input | 1 | Synchronized external clock / gate input |
| idle_i | input | 1 | Core idle status |
| sleep_i | input | 1 | Core sleep status |
| count_o | output | 16 | Current count |
| match_o | output | 1 | One-cycle period-match pulse |
| flag_o | output | 1 | Sticky event flag |
| gate_end_o | output | 1 | Gate window end pulse |

## Verification
A corrupted prescaler residue shows up only through delayed or early count steps. At ratio 1:256 such an error can take up to 256 source ticks to appear on `count_o`, so the bench runs long windows at every ratio. A wrong count or period comparison appears at the wrap: `match_o` and `flag_o` fire too early, too late, or never. A wrong edge-detect register shows up in the same or the following cycle as a missed or doubled external step, or as a misplaced `gate_end_o`.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int PS_W = 8;

  // MSB first: bit6 idle_stop .. bit0 en
  typedef struct packed {
    logic       idle_stop;
    logic [1:0] ps;
    logic       gate_en;
    logic       ext_sync;
    logic       clk_ext;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } wsel_e;

  function automatic logic [PS_W-1:0] ps_last(input logic [1:0] ps);
    case (ps)
      2'b00:   ps_last = PS_W'(0);
      2'b01:   ps_last = PS_W'(7);
      2'b10:   ps_last = PS_W'(63);
      default: ps_last = PS_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [CW-1:0] wr_data_i,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] period_o,
  output logic          cnt_wr_o,
  output logic          ctrl_wr_o
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] period_q;
  wsel_e         sel;

  assign sel       = wsel_e'(wr_sel_i);
  assign cnt_wr_o  = wr_en_i && (sel == SEL_COUNT);
  assign ctrl_wr_o = wr_en_i && (sel == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else if (wr_en_i) begin
      if (sel == SEL_PERIOD) period_q <= wr_data_i;
      if (sel == SEL_CTRL)   ctrl_q   <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end
  end

  assign ctrl_o   = ctrl_q;
  assign period_o = period_q;
endmodule

// File: rtl/gpt_src.sv
module gpt_src
  import gpt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  ext_i,
  input  logic  idle_i,
  input  logic  sleep_i,
  output logic  tick_o,
  output logic  gate_end_o
);
  logic ext_q, rise, fall, raw, idle_hold, sleep_hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_i;
  end

  assign rise = ext_i & ~ext_q;
  assign fall = ~ext_i & ext_q;

  always_comb begin
    if (ctrl_i.clk_ext)      raw = rise;
    else if (ctrl_i.gate_en) raw = ext_i;
    else                     raw = 1'b1;
  end

  assign idle_hold  = idle_i & ctrl_i.idle_stop;
  // sleep keeps only the unsynchronized external source alive
  assign sleep_hold = sleep_i & ~(ctrl_i.clk_ext & ~ctrl_i.ext_sync);
  assign tick_o     = ctrl_i.en & raw & ~idle_hold & ~sleep_hold;
  assign gate_end_o = ctrl_i.en & ctrl_i.gate_en & ~ctrl_i.clk_ext & fall;
endmodule

// File: rtl/gpt_prescale.sv
module gpt_prescale
  import gpt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [1:0] ps_i,
  input  logic       tick_i,
  output logic       tick_o
);
  logic [PS_W-1:0] cnt_q;
  logic            term;

  assign term   = (cnt_q == ps_last(ps_i));
  assign tick_o = tick_i & term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i && en_i) cnt_q <= '0;   // halted prescaler ignores clears
    else if (tick_i)        cnt_q <= term ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/gpt_core.sv
module gpt_core #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic [CW-1:0] period_i,
  input  logic          flag_clr_i,
  output logic [CW-1:0] count_o,
  output logic          match_o,
  output logic          flag_o
);
  logic [CW-1:0] count_q;
  logic          match_set, match_q, flag_q;

  assign match_set = tick_i & ~cnt_wr_i & (count_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (cnt_wr_i)    count_q <= wr_data_i;
      else if (tick_i) count_q <= match_set ? '0 : count_q + 1'b1;
      match_q <= match_set;
      flag_q  <= match_set | (flag_q & ~flag_clr_i);
    end
  end

  assign count_o = count_q;
  assign match_o = match_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          flag_clr_i,
  input  logic          ext_i,
  input  logic          idle_i,
  input  logic          sleep_i,
  output logic [CW-1:0] count_o,
  output logic          match_o,
  output logic          flag_o,
  output logic          gate_end_o
);
  ctrl_t         ctrl;
  logic [CW-1:0] period;
  logic          cnt_wr, ctrl_wr, src_tick, ps_tick;
  logic          ctl_en, ctl_idle_stop;

  assign ctl_en        = ctrl.en;
  assign ctl_idle_stop = ctrl.idle_stop;

  gpt_regs #(.CW(CW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .ctrl_o(ctrl), .period_o(period), .cnt_wr_o(cnt_wr), .ctrl_wr_o(ctrl_wr)
  );

  gpt_src u_src (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .ext_i, .idle_i, .sleep_i,
    .tick_o(src_tick), .gate_end_o
  );

  gpt_prescale u_ps (
    .clk_i, .rst_ni, .en_i(ctrl.en), .clr_i(cnt_wr | ctrl_wr),
    .ps_i(ctrl.ps), .tick_i(src_tick), .tick_o(ps_tick)
  );

  gpt_core #(.CW(CW)) u_core (
    .clk_i, .rst_ni, .tick_i(ps_tick), .cnt_wr_i(cnt_wr), .wr_data_i,
    .period_i(period), .flag_clr_i, .count_o, .match_o, .flag_o
  );
endmodule

// File: rtl/gpt_chk.sv
module gpt_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    wr_sel_i,
  input logic          ext_i,
  input logic          idle_i,
  input logic          flag_clr_i,
  input logic          en_i,
  input logic          idle_stop_i,
  input logic [CW-1:0] count_o,
  input logic          match_o,
  input logic          flag_o,
  input logic          gate_end_o
);
  logic cnt_wr;
  assign cnt_wr = wr_en_i && (wr_sel_i == 2'd0);

  a_r7_match_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (count_o == '0));

  a_r8_flag_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> flag_o);

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  a_r11_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr) |=> $stable(count_o));

  a_r9_idle_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && idle_stop_i && !cnt_wr) |=> $stable(count_o));

  a_r6_gate_end_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_end_o |-> !ext_i);

  a_r5_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr |=> ($stable(count_o) || count_o == '0 ||
                 count_o == $past(count_o) + 1'b1));
endmodule

bind gp_timer gpt_chk #(.CW(CW)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .ext_i, .idle_i, .flag_clr_i,
  .en_i(ctl_en), .idle_stop_i(ctl_idle_stop),
  .count_o, .match_o, .flag_o, .gate_end_o
);

// File: tb/tb_gp_timer.sv
module tb_gp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        flag_clr = 1'b0, ext = 1'b0, idle = 1'b0, sleep = 1'b0;
  logic [15:0] count;
  logic        match, flag, gate_end;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  gp_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .flag_clr_i(flag_clr), .ext_i(ext), .idle_i(idle),
    .sleep_i(sleep), .count_o(count), .match_o(match), .flag_o(flag),
    .gate_end_o(gate_end)
  );

  // reference model state
  logic [15:0] m_cnt, m_per;
  logic [6:0]  m_ctl;
  logic [7:0]  m_ps;
  logic        m_extq, m_match, m_flag;

  function automatic logic [7:0] ratio_last(input logic [1:0] f);
    case (f)
      2'b00: return 8'd0;
      2'b01: return 8'd7;
      2'b10: return 8'd63;
      default: return 8'd255;
    endcase
  endfunction

  function automatic logic exp_gate_end();
    return m_ctl[0] & m_ctl[3] & ~m_ctl[1] & m_extq & ~ext;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 16'd0; m_per = 16'hFFFF; m_ctl = 7'd0; m_ps = 8'd0;
      m_extq = 1'b0; m_match = 1'b0; m_flag = 1'b0;
    end else begin
      logic en, cext, raw, tick, term, ptick, cwr, kwr, mset;
      en   = m_ctl[0];
      cext = m_ctl[1];
      raw  = cext ? (ext & ~m_extq) : (m_ctl[3] ? ext : 1'b1);
      tick = en & raw & ~(idle & m_ctl[6]) & ~(sleep & ~(cext & ~m_ctl[2]));
      term = (m_ps == ratio_last(m_ctl[5:4]));
      ptick = tick & term;
      cwr  = wr_en && wr_sel == 2'd0;
      kwr  = wr_en && wr_sel == 2'd2;
      mset = ptick & ~cwr & (m_cnt == m_per);
      if ((cwr | kwr) & en) m_ps = 8'd0;
      else if (tick)        m_ps = term ? 8'd0 : m_ps + 8'd1;
      if (cwr)        m_cnt = wr_data;
      else if (ptick) m_cnt = mset ? 16'd0 : m_cnt + 16'd1;
      m_flag  = mset | (m_flag & ~flag_clr);
      m_match = mset;
      if (wr_en && wr_sel == 2'd1) m_per = wr_data;
      if (kwr) m_ctl = wr_data[6:0];
      m_extq = ext;
    end
  end

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // inputs set before call; sample comb output before edge, registers after
  task automatic cyc();
    #1;
    chk("gate_end", {15'd0, gate_end}, {15'd0, exp_gate_end()});
    @(negedge clk);
    chk("count", count, m_cnt);
    chk("match", {15'd0, match}, {15'd0, m_match});
    chk("flag", {15'd0, flag}, {15'd0, m_flag});
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] cw(input bit en, input bit cext, input bit sync,
                                     input bit gate, input logic [1:0] ps, input bit istop);
    return {9'd0, istop, ps, gate, sync, cext, en};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk("count", count, 16'd0);
    chk("match", {15'd0, match}, 16'd0);
    chk("flag", {15'd0, flag}, 16'd0);
    chk("gate_end", {15'd0, gate_end}, 16'd0);
    rst_n = 1'b1;
    run(3);

    // R3 explicit: 1:8, 16 internal cycles -> count 2
    cur_req = "R3";
    wr(2'd2, cw(1, 0, 0, 0, 2'b01, 0));
    run(16);
    chk("count_1to8_explicit", count, 16'd2);
    for (int p = 0; p < 4; p++) begin
      wr(2'd2, cw(1, 0, 0, 0, p[1:0], 0));
      run(600);
    end

    // R2 register writes, control write keeps count, sel 3 ignored
    cur_req = "R2";
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h1234);
    chk("count_written", count, 16'h1234);
    wr(2'd2, 16'hFF80);
    chk("count_after_ctrl", count, 16'h1234);
    wr(2'd3, 16'h0001);
    run(4);
    chk("sel3_ignored", count, 16'h1234);

    // R5 R7 internal source and period wrap
    cur_req = "R7";
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd5);
    wr(2'd2, cw(1, 0, 0, 0, 2'b00, 0));
    run(30);
    cur_req = "R5";
    wr(2'd2, cw(1, 1, 1, 0, 2'b00, 0));
    for (int i = 0; i < 40; i++) begin ext = i[1]; cyc(); end
    ext = 1'b1; run(5);
    ext = 1'b0; run(2);

    // R4 clears and write priority
    cur_req = "R4";
    wr(2'd1, 16'hFFFF);
    wr(2'd2, cw(1, 0, 0, 0, 2'b01, 0));
    run(5);
    wr(2'd0, 16'd100);
    run(7);
    chk("no_step_after_clear", count, 16'd100);
    run(1);
    chk("step_8_after_clear", count, 16'd101);
    run(3);
    wr(2'd2, cw(1, 0, 0, 0, 2'b01, 0));
    run(10);
    wr(2'd2, cw(1, 0, 0, 0, 2'b00, 0));
    wr(2'd0, 16'd7);
    chk("write_beats_tick", count, 16'd7);

    // R6 gate mode
    cur_req = "R6";
    wr(2'd2, cw(1, 0, 0, 1, 2'b00, 0));
    for (int i = 0; i < 60; i++) begin ext = ($urandom_range(0, 2) != 0); cyc(); end
    ext = 1'b1; cyc(); ext = 1'b0; cyc();
    ext = 1'b0;

    // R8 flag sticky and clear
    cur_req = "R8";
    wr(2'd1, 16'd2);
    wr(2'd0, 16'd0);
    run(12);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    run(6);

    // R9 idle
    cur_req = "R9";
    wr(2'd2, cw(1, 0, 0, 0, 2'b01, 1));
    run(3);
    idle = 1'b1;
    run(20);
    idle = 1'b0; run(10);
    wr(2'd2, cw(1, 0, 0, 0, 2'b00, 0));
    idle = 1'b1; run(10); idle = 1'b0;

    // R10 sleep
    cur_req = "R10";
    wr(2'd1, 16'hFFFF);
    sleep = 1'b1; run(10);
    sleep = 1'b0;
    wr(2'd2, cw(1, 1, 1, 0, 2'b00, 0));
    sleep = 1'b1;
    for (int i = 0; i < 20; i++) begin ext = i[0]; cyc(); end
    sleep = 1'b0;
    wr(2'd2, cw(1, 1, 0, 0, 2'b00, 0));
    sleep = 1'b1;
    for (int i = 0; i < 20; i++) begin ext = i[0]; cyc(); end
    sleep = 1'b0; ext = 1'b0;

    // R11 disabled
    cur_req = "R11";
    wr(2'd2, cw(0, 0, 0, 0, 2'b00, 0));
    run(20);
    wr(2'd0, 16'd9);
    run(5);
    chk("disabled_hold", count, 16'd9);

    // random mix over R2 to R11
    cur_req = "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random";
    for (int i = 0; i < 6000; i++) begin
      wr_en = ($urandom_range(0, 9) == 0);
      wr_sel = 2'($urandom_range(0, 3));
      case (wr_sel)
        2'd0: wr_data = 16'($urandom_range(0, 24));
        2'd1: wr_data = 16'($urandom_range(0, 24));
        default: begin
          wr_data = 16'($urandom);
          if ($urandom_range(0, 3) != 0) wr_data[5:4] = 2'b00;
          if ($urandom_range(0, 4) != 0) wr_data[0] = 1'b1;
        end
      endcase
      flag_clr = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 2) == 0) ext = ~ext;
      idle  = ($urandom_range(0, 9) == 0);
      sleep = ($urandom_range(0, 9) == 0);
      cyc();
    end
    wr_en = 1'b0; flag_clr = 1'b0; idle = 1'b0; sleep = 1'b0;
    run(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule